// File: doc/BRIEF.md
# Input change-of-state detector

This block watches a small group of general-purpose input pins and remembers every transition on each of them. Each pin passes through a two-flop synchroniser and then a stability filter. The filter accepts a new level only when the synchronised value is the same at two consecutive sample strobes. Each accepted change of level sets a sticky per-pin change flag and a shared summary change bit.

The host reads one 8-bit port-change word. Bits 7..4 hold the change flags for pins 3..0, and bits 3..0 hold the present filtered levels of pins 3..0. The word is always visible on `rdata_o`. Pulsing `rd_i` for one cycle marks the read. At that clock edge every change flag and the summary bit are cleared. The one exception is a flag whose own change is accepted at the same edge: that flag stays set, so the event is not lost.

A level-sensitive enable gates the summary bit onto the interrupt request.

Top module: `icd_top`

## Requirements
- R1: After reset, with all pins held low, `rdata_o` is 0x00, and `chg_o` and `irq_o` are both low.
- R2: A pin held at a new level for at least three sample periods appears on the level field: bit n of `rdata_o` for pin n (n = 0..3).
- R3: Each accepted change of pin n sets bit 4+n of `rdata_o`, for both rising and falling changes. The bit stays set through further changes until a read.
- R4: A pulse on a pin that lasts no longer than one sample period (`SAMPLE_DIV` cycles) changes neither the level field nor the change field.
- R5: A clock edge with `rd_i` high clears bits 7..4 of `rdata_o` and clears `chg_o`, when no change is accepted at that edge. Bits 3..0 are not affected.
- R6: `chg_o` goes high at the edge where any change flag is set, and stays high until a read.
- R7: `irq_o` is high exactly when `irq_en_i` is high and `chg_o` is high.
- R8: A change accepted at the same edge as a read leaves that pin's change flag set and leaves `chg_o` high. All other flags are still cleared.
- R9: Pins that change together set each of their own change flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pins_i | input | 4 | Asynchronous general-purpose inputs |
| rd_i | input | 1 | One-cycle strobe marking a host read of the port-change word |
| irq_en_i | input | 1 | Lets the summary change bit drive the interrupt request |
| rdata_o | output | 8 | Port-change word: change flags in bits 7..4, filtered levels in bits 3..0 |
| chg_o | output | 1 | Summary input-change status bit |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the collision: a read that lands on exactly the edge where the filter accepts a new level. The stimulus takes the sample-strobe phase from the ports. It toggles a pin and watches for the edge where the level bit flips, which is always a strobe edge. It then toggles the pin back right after that edge, so the return is accepted exactly two sample periods later, and places the read strobe on that edge. Glitch rejection is checked with a two-cycle pulse placed between strobes.

// File: rtl/icd_pkg.sv
package icd_pkg;
  localparam int unsigned PIN_W = 4;
  localparam int unsigned WORD_W = 2 * PIN_W;
  typedef logic [PIN_W-1:0] pin_vec_t;
endpackage

// File: rtl/icd_sync.sv
module icd_sync #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_i[g];
        stab_q <= meta_q;
      end
    end
    assign sync_o[g] = stab_q;
  end
endmodule

// File: rtl/icd_filter.sv
module icd_filter #(
  parameter int unsigned WIDTH      = 4,
  parameter int unsigned SAMPLE_DIV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sync_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] change_o
);
  localparam int unsigned CNT_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SAMPLE_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             tick;
  logic [WIDTH-1:0] cand_q, level_q;

  assign tick = (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    logic accept;
    // accept only a value seen at two consecutive strobes
    assign accept = tick && (sync_i[g] == cand_q[g]) && (sync_i[g] != level_q[g]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cand_q[g]  <= 1'b0;
        level_q[g] <= 1'b0;
      end else if (tick) begin
        cand_q[g] <= sync_i[g];
        if (accept) level_q[g] <= sync_i[g];
      end
    end
    assign change_o[g] = accept;
  end

  assign level_o = level_q;

  p_level_on_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(level_q));
endmodule

// File: rtl/icd_delta.sv
module icd_delta #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] change_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] delta_o,
  output logic             chg_o
);
  logic [WIDTH-1:0] delta_q;
  logic             chg_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          delta_q[g] <= 1'b0;
      else if (change_i[g]) delta_q[g] <= 1'b1;  // set wins over read
      else if (rd_i)        delta_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         chg_q <= 1'b0;
    else if (|change_i)  chg_q <= 1'b1;
    else if (rd_i)       chg_q <= 1'b0;
  end

  assign delta_o = delta_q;
  assign chg_o   = chg_q;

  p_clear_on_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && change_i == '0) |=> (delta_q == '0 && !chg_q));
  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (change_i != '0) |=> ((delta_q & $past(change_i)) == $past(change_i)));
  p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> ((delta_q & $past(delta_q)) == $past(delta_q)));
  p_summary_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (change_i != '0) |=> chg_q);
endmodule

// File: rtl/icd_top.sv
module icd_top
  import icd_pkg::*;
#(
  parameter int unsigned SAMPLE_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PIN_W-1:0]  pins_i,
  input  logic              rd_i,
  input  logic              irq_en_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              chg_o,
  output logic              irq_o
);
  pin_vec_t sync_w, level_w, change_w, delta_w;
  logic     chg_w;

  icd_sync #(.WIDTH(PIN_W)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(pins_i), .sync_o(sync_w)
  );

  icd_filter #(.WIDTH(PIN_W), .SAMPLE_DIV(SAMPLE_DIV)) u_filter (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_w),
    .level_o(level_w), .change_o(change_w)
  );

  icd_delta #(.WIDTH(PIN_W)) u_delta (
    .clk_i(clk_i), .rst_ni(rst_ni), .change_i(change_w), .rd_i(rd_i),
    .delta_o(delta_w), .chg_o(chg_w)
  );

  assign rdata_o = {delta_w, level_w};
  assign chg_o   = chg_w;
  assign irq_o   = irq_en_i & chg_w;

  p_irq_has_delta_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (rdata_o[WORD_W-1:PIN_W] != '0));
  p_chg_matches_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[WORD_W-1:PIN_W] != '0) |-> chg_o);
endmodule

// File: tb/tb_icd_top.sv
`timescale 1ns/1ps
module tb_icd_top;
  localparam int DIV = 4;
  localparam int SETTLE = 3 * DIV + 4;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] pins = 0;
  logic       rd = 0;
  logic       irq_en = 0;
  logic [7:0] rdata;
  logic       chg, irq;
  int         errors = 0, checks = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  icd_top #(.SAMPLE_DIV(DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .rd_i(rd), .irq_en_i(irq_en),
    .rdata_o(rdata), .chg_o(chg), .irq_o(irq)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    rd = 1; cyc(1); rd = 0;
  endtask

  task automatic t_reset();
    cyc(2);
    check("R1 rdata", rdata, 8'h00);
    check("R1 chg", {7'b0, chg}, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_rise();
    pins[2] = 1; cyc(SETTLE);
    check("R2 R3 rise pin2", rdata, 8'h44);
    check("R6 chg set", {7'b0, chg}, 8'h01);
    pins[2] = 0; cyc(SETTLE);
    check("R3 sticky after fall", rdata, 8'h40);
  endtask

  task automatic t_read_clear();
    do_read();
    check("R5 clear", rdata, 8'h00);
    check("R5 chg clear", {7'b0, chg}, 8'h00);
  endtask

  task automatic t_fall();
    pins[1] = 1; cyc(SETTLE); do_read();
    check("R5 level kept", rdata, 8'h02);
    pins[1] = 0; cyc(SETTLE);
    check("R3 fall pin1", rdata, 8'h20);
    do_read();
  endtask

  task automatic t_glitch();
    pins[3] = 1; cyc(2); pins[3] = 0; cyc(SETTLE);
    check("R4 glitch ignored", rdata, 8'h00);
    check("R4 no chg", {7'b0, chg}, 8'h00);
  endtask

  task automatic t_irq();
    irq_en = 0; pins[0] = 1; cyc(SETTLE);
    check("R7 masked", {7'b0, irq}, 8'h00);
    irq_en = 1; #1;
    check("R7 enabled", {7'b0, irq}, 8'h01);
    do_read();
    check("R7 cleared", {7'b0, irq}, 8'h00);
    pins[0] = 0; cyc(SETTLE); do_read();
    irq_en = 0;
  endtask

  task automatic t_multi();
    pins = 4'b1010; cyc(SETTLE);
    check("R9 multi", rdata, 8'hAA);
    do_read();
    pins = 4'b0000; cyc(SETTLE); do_read();
    check("R9 back", rdata, 8'h00);
  endtask

  task automatic t_collision();
    int k;
    pins[0] = 1;
    k = 0;
    while (rdata[0] !== 1'b1 && k < 100) begin cyc(1); k++; end
    // just after the strobe edge that accepted the level
    pins[0] = 0; rd = 1; cyc(1); rd = 0;
    check("R5 pre-clear", rdata, 8'h01);
    cyc(2 * DIV - 2);
    rd = 1; cyc(1); rd = 0;
    check("R8 kept on collision", rdata, 8'h10);
    check("R8 chg kept", {7'b0, chg}, 8'h01);
    do_read();
    check("R5 later clear", rdata, 8'h00);
  endtask

  initial begin
    cyc(3); rst_n = 1;
    t_reset();
    t_rise();
    t_read_clear();
    t_fall();
    t_glitch();
    t_irq();
    t_multi();
    t_collision();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule